// File: doc/BRIEF.md
# Parallel I/O Port Controller

This block manages a port of up to 32 pins behind a small word-addressed register interface. Each pin belongs to one of three owners: the block's own general-purpose output logic, peripheral A, or peripheral B. Under general-purpose control, a per-pin output latch and a per-pin driver enable set the pad. Under peripheral control, the selected peripheral's data and enable pass straight to the pad.

Every per-pin control is a group of three registers: a write-one-to-set address, a write-one-to-clear address and a read-only status address. Software changes single pins without any read-modify-write. There are six such groups: ownership, driver enable, output data, pull-up, multi-driver (open-drain) and peripheral choice. One further address returns the level seen at the pads. Multi-driver mode works for any owner. In that mode the pad only ever pulls low, and a logic 1 releases the pin.

Top module: `pio_port`

## Requirements
- R1: After reset, every pin is owned by the general-purpose logic (ownership status all ones), drivers are off, output data is 0, pull-ups are on (all ones), multi-driver mode is off and peripheral A is chosen (choice status 0).
- R2: The register groups sit at word addresses 3k (set), 3k+1 (clear) and 3k+2 (status), with k = 0 ownership (1 = general-purpose), 1 driver enable, 2 output data, 3 pull-up, 4 multi-driver, 5 peripheral choice (1 = B). Writing a 1 to a bit of a set or clear address sets or clears that pin's bit. A 0 leaves that bit unchanged.
- R3: A pin owned by the general-purpose logic with multi-driver off drives pad_out from its output-data bit and pad_oe from its driver-enable bit.
- R4: A pin not owned by the general-purpose logic, with multi-driver off, takes pad_out and pad_oe from peripheral A when its choice bit is 0 and from peripheral B when it is 1.
- R5: A pin in multi-driver mode always has pad_out 0. Its pad_oe is 1 only when the owner enables the driver and the owner's data is 0.
- R6: pad_pullup equals the pull-up status for every pin.
- R7: A read of address 18 returns pad_in.
- R8: Writes to status addresses, to address 18 or to addresses above 18 change no state. Reads of set, clear and unmapped addresses return 0.
- R9: A write takes effect at the clock edge on which bus_we is sampled. Pad outputs do not change before that edge and show the new value right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Level seen at the pads |
| per_a_out | input | 32 | Peripheral A output data |
| per_a_oe | input | 32 | Peripheral A driver enable |
| per_b_out | input | 32 | Peripheral B output data |
| per_b_oe | input | 32 | Peripheral B driver enable |
| pad_out | output | 32 | Pad output data |
| pad_oe | output | 32 | Pad driver enable |
| pad_pullup | output | 32 | Pad pull-up enable |

## Verification
The assertions assume that bus_addr and bus_wdata are settled whenever bus_we is high at a clock edge. They also assume one write per cycle, so a set address and its clear address are never hit together. The bench changes every input on the falling clock edge and holds bus_we high for exactly one rising edge per write, so this assumption always holds. Peripheral inputs are held steady while pad checks are sampled, so the pad values follow only from the stored register state.

// File: rtl/pio_port_pkg.sv
package pio_port_pkg;
    localparam int CTL_OWN  = 0;
    localparam int CTL_OE   = 1;
    localparam int CTL_DATA = 2;
    localparam int CTL_PULL = 3;
    localparam int CTL_MD   = 4;
    localparam int CTL_SEL  = 5;
    localparam int NUM_CTL  = 6;
    localparam int REGS_PER_CTL = 3;
    localparam int LEVEL_WORD = NUM_CTL * REGS_PER_CTL;

    function automatic bit ctl_resets_high(input int k);
        return (k == CTL_OWN) || (k == CTL_PULL);
    endfunction
endpackage

// File: rtl/pio_ctl_triple.sv
module pio_ctl_triple #(
    parameter int W = 32,
    parameter bit RST_ONES = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_hit,
    input  logic         clr_hit,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] RST_VAL = RST_ONES ? {W{1'b1}} : {W{1'b0}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (set_hit)
            q <= q | wbits;
        else if (clr_hit)
            q <= q & ~wbits;
    end
endmodule

// File: rtl/pio_pin_mux.sv
module pio_pin_mux #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] own_gpio,
    input  logic [NPINS-1:0] gpio_data,
    input  logic [NPINS-1:0] gpio_oe,
    input  logic [NPINS-1:0] sel_b,
    input  logic [NPINS-1:0] md_mode,
    input  logic [NPINS-1:0] a_out,
    input  logic [NPINS-1:0] a_oe,
    input  logic [NPINS-1:0] b_out,
    input  logic [NPINS-1:0] b_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic src_out;
        logic src_oe;

        always_comb begin
            if (own_gpio[i]) begin
                src_out = gpio_data[i];
                src_oe  = gpio_oe[i];
            end else if (sel_b[i]) begin
                src_out = b_out[i];
                src_oe  = b_oe[i];
            end else begin
                src_out = a_out[i];
                src_oe  = a_oe[i];
            end
        end

        always_comb begin
            if (md_mode[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = src_oe & ~src_out;
            end else begin
                pad_out[i] = src_out;
                pad_oe[i]  = src_oe;
            end
        end
    end
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_port_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] per_a_out,
    input  logic [NPINS-1:0] per_a_oe,
    input  logic [NPINS-1:0] per_b_out,
    input  logic [NPINS-1:0] per_b_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pullup
);
    localparam logic [AW-1:0] LEVEL_ADDR = AW'(LEVEL_WORD);

    logic [NUM_CTL-1:0][NPINS-1:0] ctl_q;
    logic [NPINS-1:0] own_q, oe_q, data_q, pull_q, md_q, selb_q;

    for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
        localparam logic [AW-1:0] SET_ADDR = AW'(REGS_PER_CTL * k);
        localparam logic [AW-1:0] CLR_ADDR = AW'(REGS_PER_CTL * k + 1);

        pio_ctl_triple #(
            .W        (NPINS),
            .RST_ONES (ctl_resets_high(k))
        ) u_triple (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_hit (bus_we && (bus_addr == SET_ADDR)),
            .clr_hit (bus_we && (bus_addr == CLR_ADDR)),
            .wbits   (bus_wdata),
            .q       (ctl_q[k])
        );
    end

    assign own_q  = ctl_q[CTL_OWN];
    assign oe_q   = ctl_q[CTL_OE];
    assign data_q = ctl_q[CTL_DATA];
    assign pull_q = ctl_q[CTL_PULL];
    assign md_q   = ctl_q[CTL_MD];
    assign selb_q = ctl_q[CTL_SEL];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == LEVEL_ADDR)
            bus_rdata = pad_in;
        for (int k = 0; k < NUM_CTL; k++) begin
            if (bus_addr == AW'(REGS_PER_CTL * k + 2))
                bus_rdata = ctl_q[k];
        end
    end

    pio_pin_mux #(.NPINS(NPINS)) u_mux (
        .own_gpio  (own_q),
        .gpio_data (data_q),
        .gpio_oe   (oe_q),
        .sel_b     (selb_q),
        .md_mode   (md_q),
        .a_out     (per_a_out),
        .a_oe      (per_a_oe),
        .b_out     (per_b_out),
        .b_oe      (per_b_oe),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    assign pad_pullup = pull_q;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
    parameter int NPINS = 32,
    parameter int AW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [NPINS-1:0] bus_wdata,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_pullup,
    input logic [NPINS-1:0] own_q,
    input logic [NPINS-1:0] oe_q,
    input logic [NPINS-1:0] data_q,
    input logic [NPINS-1:0] pull_q,
    input logic [NPINS-1:0] md_q,
    input logic [NPINS-1:0] selb_q
);
    // R2
    oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(3)) |=> ((oe_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R2
    oe_set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(3)) |=> ((oe_q & ~$past(bus_wdata)) == ($past(oe_q) & ~$past(bus_wdata))));

    // R2
    data_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(7)) |=> ((data_q & $past(bus_wdata)) == '0));

    // R3
    gpio_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & own_q & ~md_q) == (data_q & own_q & ~md_q)) &&
        ((pad_oe & own_q & ~md_q) == (oe_q & own_q & ~md_q)));

    // R5
    md_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & md_q) == '0);

    // R6
    pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pullup == pull_q);

    // R8
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr >= AW'(18)) |=>
        ($stable(own_q) && $stable(oe_q) && $stable(data_q) &&
         $stable(pull_q) && $stable(md_q) && $stable(selb_q)));
endmodule

bind pio_port pio_port_chk #(.NPINS(NPINS), .AW(AW)) u_pio_port_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pad_pullup (pad_pullup),
    .own_q      (own_q),
    .oe_q       (oe_q),
    .data_q     (data_q),
    .pull_q     (pull_q),
    .md_q       (md_q),
    .selb_q     (selb_q)
);

// File: tb/test_pio_port.sv
`timescale 1ns/1ps
module test_pio_port;
    localparam int N = 32;
    localparam int AW = 5;
    localparam int NVEC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] per_a_out = '0, per_a_oe = '0, per_b_out = '0, per_b_oe = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pullup;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pio_port #(.NPINS(N), .AW(AW)) i_pio_port (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .per_a_out(per_a_out), .per_a_oe(per_a_oe),
        .per_b_out(per_b_out), .per_b_oe(per_b_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup)
    );

    // {write address, write data, status address, expected status}
    localparam logic [73:0] VEC [NVEC] = '{
        {5'd3,  32'h0000_00FF, 5'd5,  32'h0000_00FF},
        {5'd4,  32'h0000_000F, 5'd5,  32'h0000_00F0},
        {5'd6,  32'hA5A5_0000, 5'd8,  32'hA5A5_0000},
        {5'd7,  32'h8000_0000, 5'd8,  32'h25A5_0000},
        {5'd6,  32'h0000_0000, 5'd8,  32'h25A5_0000},
        {5'd10, 32'hFFFF_0000, 5'd11, 32'h0000_FFFF},
        {5'd12, 32'h0000_0003, 5'd14, 32'h0000_0003},
        {5'd1,  32'h0000_FF00, 5'd2,  32'hFFFF_00FF},
        {5'd15, 32'h0000_F000, 5'd17, 32'h0000_F000},
        {5'd16, 32'h0000_3000, 5'd17, 32'h0000_C000}
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [2*N-1:0] model(
        input logic [N-1:0] own, data, oe, md, selb, ao, ae, bo, be);
        logic [N-1:0] o, e;
        for (int i = 0; i < N; i++) begin
            logic so, se;
            so = own[i] ? data[i] : (selb[i] ? bo[i] : ao[i]);
            se = own[i] ? oe[i]   : (selb[i] ? be[i] : ae[i]);
            o[i] = md[i] ? 1'b0 : so;
            e[i] = md[i] ? (se & ~so) : se;
        end
        return {o, e};
    endfunction

    initial begin
        logic [N-1:0] r;
        logic [2*N-1:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'd2, r);  check("R1 own", r, '1);
        rd(5'd5, r);  check("R1 oe", r, '0);
        rd(5'd8, r);  check("R1 data", r, '0);
        rd(5'd11, r); check("R1 pull", r, '1);
        rd(5'd14, r); check("R1 md", r, '0);
        rd(5'd17, r); check("R1 sel", r, '0);
        check("R1 pad_oe", pad_oe, '0);
        check("R6 pullup at reset", pad_pullup, '1);

        // R2 table walk
        for (int v = 0; v < NVEC; v++) begin
            wr(VEC[v][73:69], VEC[v][68:37]);
            rd(VEC[v][36:32], r);
            check("R2 table", r, VEC[v][31:0]);
        end

        // R6
        check("R6 pullup", pad_pullup, 32'h0000_FFFF);

        // R3/R4 with peripheral activity
        per_a_out = 32'hAAAA_AAAA; per_a_oe = 32'hFFFF_FFFF;
        per_b_out = 32'h5555_5555; per_b_oe = 32'h0F0F_0F0F;
        #1;
        m = model(32'hFFFF_00FF, 32'h25A5_0000, 32'h0000_00F0, 32'h3, 32'h0000_C000,
                  per_a_out, per_a_oe, per_b_out, per_b_oe);
        check("R3 gpio out", pad_out & 32'hFFFF_00FC, m[2*N-1:N] & 32'hFFFF_00FC);
        check("R3 gpio oe",  pad_oe  & 32'hFFFF_00FC, m[N-1:0] & 32'hFFFF_00FC);
        check("R4 periph out", pad_out & 32'h0000_FF00, 32'h0000_6A00);
        check("R4 periph oe",  pad_oe  & 32'h0000_FF00, 32'h0000_3F00);

        // R5 multi-driver on pins 0,1: pin0 data 1 -> released, pin1 data 0 -> drives low
        wr(5'd3, 32'h3);
        wr(5'd6, 32'h1);
        #1;
        check("R5 md out", pad_out & 32'h3, 32'h0);
        check("R5 md oe", pad_oe & 32'h3, 32'h2);

        // R7
        pad_in = 32'h1234_5678;
        rd(5'd18, r); check("R7 level", r, 32'h1234_5678);

        // R8
        wr(5'd2, 32'h0);
        wr(5'd20, 32'hFFFF_FFFF);
        wr(5'd18, 32'hFFFF_FFFF);
        rd(5'd2, r);  check("R8 own unchanged", r, 32'hFFFF_00FF);
        rd(5'd5, r);  check("R8 oe unchanged", r, 32'h0000_00F3);
        rd(5'd20, r); check("R8 unmapped read", r, '0);
        rd(5'd3, r);  check("R8 set addr read", r, '0);

        // R9 timing of a write on pin 31 (GPIO, data 0)
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 5'd3; bus_wdata = 32'h8000_0000;
        #1 check("R9 before edge", pad_oe & 32'h8000_0000, 32'h0);
        @(posedge clk); #1;
        bus_we = 1'b0;
        check("R9 after edge", pad_oe & 32'h8000_0000, 32'h8000_0000);

        // R1 again after a mid-run reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(5'd2, r);  check("R1 own after reset", r, '1);
        rd(5'd8, r);  check("R1 data after reset", r, '0);
        check("R1 pad_oe after reset", pad_oe, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule